// File: doc/BRIEF.md
# Strided Wrap Counter

This block produces an index sequence on chip, so a host does not have to stream a loop variable next to its data. Each cycle it presents a count and a one-cycle wrap flag. The count starts at zero, advances by a step while enabled, and returns to zero at a wrap point.

The wrap point and the step are scalar values written by the host. The block copies them into working registers only on a one-cycle stream-start strobe. Host writes that land during a stream therefore take effect at the next stream. Reset leaves the block running with a wrap point of all ones and a step of one, which reproduces the plain loop index 0, 1, 2, ...

The control is a two-state machine. PH_CLIMB means the count is below the captured wrap point. PH_TOP means the count equals it. There are four transitions:
- CLIMB→TOP: an enabled step lands exactly on the wrap point.
- TOP→CLIMB: the forced return to zero, when the wrap point is nonzero.
- TOP→TOP: the return to zero when the wrap point is zero.
- CLIMB→CLIMB: any other step, hold or overshoot wrap.

A start strobe places the machine in PH_TOP when the new wrap point is zero, and in PH_CLIMB otherwise.

Top module: `strided_wrap_counter`

## Requirements
- R1: After synchronous reset the count is 0 and wrap is 0. The working wrap point is all ones and the working step is 1, so with enable held high the count reads 0, 1, 2, ... up to all ones.
- R2: When start is high at a clock edge, cfg_max and cfg_step are captured into the working registers, and the count becomes 0 with wrap 0. Start takes priority over enable and over a pending wrap.
- R3: Changes on cfg_max and cfg_step while start is low have no effect on the count sequence of the running stream.
- R4: With enable high and count below the working wrap point, if count plus step (computed without loss of carry) is at most the wrap point, the next count is count plus step and wrap is 0.
- R5: With enable low and count below the working wrap point, the count holds and wrap is 0.
- R6: When the count equals the working wrap point, the next count is 0 and wrap is 1, whatever the enable.
- R7: With enable high and count below the wrap point, if count plus step exceeds the wrap point (including a carry out of the count width), the next count is 0 and wrap is 1.
- R8: A working wrap point of 0 gives a count of 0 with wrap 1 on every cycle of the stream after the start cycle.
- R9: The count never exceeds the working wrap point, and wrap is 1 only on a cycle where the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| start | input | 1 | Stream-start strobe; captures parameters and restarts at 0 |
| cfg_max | input | WIDTH | Host-written wrap point |
| cfg_step | input | WIDTH | Host-written step |
| count | output | WIDTH | Current index |
| wrap | output | 1 | High on the cycle the count has returned to zero by wrapping |

## Verification
The bench runs every pair of wrap point and step in a 4-bit configuration, steps of 0 and wrap points of 0 included.

Enable follows an irregular on/off pattern. This separates holding (R5) from stepping (R4), and shows that the forced return from the wrap point happens even while enable is low (R6).

Steps that do not divide the wrap point expose the overshoot rule (R7), and large steps also exercise the carry-out case.

Scrambled host values are driven throughout each stream to tell captured parameters from live ones (R3). The run from the reset defaults confirms the plain index sequence (R1).

// File: rtl/wrapctr_pkg.sv
package wrapctr_pkg;
    // PH_CLIMB: count below the working wrap point
    // PH_TOP  : count equals the working wrap point
    typedef enum logic {
        PH_CLIMB = 1'b0,
        PH_TOP   = 1'b1
    } phase_e;
endpackage

// File: rtl/wrapctr_capture.sv
module wrapctr_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] cfg_max,
    input  logic [W-1:0] cfg_step,
    output logic [W-1:0] max_q,
    output logic [W-1:0] step_q
);
    localparam logic [W-1:0] DEF_MAX  = '1;
    localparam logic [W-1:0] DEF_STEP = W'(1);

    // Parameters are latched only on the start strobe and then held
    always_ff @(posedge clk) begin
        if (rst) begin
            max_q  <= DEF_MAX;
            step_q <= DEF_STEP;
        end else if (start) begin
            max_q  <= cfg_max;
            step_q <= cfg_step;
        end
    end
endmodule

// File: rtl/wrapctr_adv.sv
module wrapctr_adv #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] step,
    input  logic [W-1:0] lim,
    output logic [W-1:0] sum,
    output logic         hit,
    output logic         over
);
    localparam int XW = W + 1;

    logic [XW-1:0] ext_sum;
    logic [XW-1:0] ext_lim;

    // One extra bit keeps the carry, so a wrap past the top of the
    // count range reads as an overshoot instead of a small value
    always_comb begin
        ext_sum = {1'b0, cur} + {1'b0, step};
        ext_lim = {1'b0, lim};
        sum     = ext_sum[W-1:0];
        hit     = (ext_sum == ext_lim);
        over    = (ext_sum >  ext_lim);
    end
endmodule

// File: rtl/strided_wrap_counter.sv
module strided_wrap_counter
    import wrapctr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [WIDTH-1:0] cfg_max,
    input  logic [WIDTH-1:0] cfg_step,
    output logic [WIDTH-1:0] count,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] max_q;
    logic [WIDTH-1:0] step_q;
    logic [WIDTH-1:0] sum;
    logic             hit;
    logic             over;

    phase_e           phase_q;
    phase_e           phase_d;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;
    logic             wrap_q;
    logic             wrap_d;

    wrapctr_capture #(.W(WIDTH)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_max  (cfg_max),
        .cfg_step (cfg_step),
        .max_q    (max_q),
        .step_q   (step_q)
    );

    wrapctr_adv #(.W(WIDTH)) u_adv (
        .cur  (count_q),
        .step (step_q),
        .lim  (max_q),
        .sum  (sum),
        .hit  (hit),
        .over (over)
    );

    // Next-state and next-output logic
    always_comb begin
        phase_d = phase_q;
        count_d = count_q;
        wrap_d  = 1'b0;
        if (start) begin
            count_d = ZERO;
            phase_d = (cfg_max == ZERO) ? PH_TOP : PH_CLIMB;
        end else begin
            unique case (phase_q)
                PH_TOP: begin
                    count_d = ZERO;
                    wrap_d  = 1'b1;
                    phase_d = (max_q == ZERO) ? PH_TOP : PH_CLIMB;
                end
                PH_CLIMB: begin
                    if (en) begin
                        if (over) begin
                            count_d = ZERO;
                            wrap_d  = 1'b1;
                        end else if (hit) begin
                            count_d = sum;
                            phase_d = PH_TOP;
                        end else begin
                            count_d = sum;
                        end
                    end
                end
                default: begin
                    count_d = ZERO;
                    phase_d = PH_CLIMB;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_CLIMB;
        else     phase_q <= phase_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= ZERO;
            wrap_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            wrap_q  <= wrap_d;
        end
    end

    assign count = count_q;
    assign wrap  = wrap_q;
endmodule

// File: rtl/strided_wrap_counter_chk.sv
module strided_wrap_counter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         start,
    input logic [W-1:0] count,
    input logic         wrap,
    input logic [W-1:0] max_w,
    input logic [W-1:0] step_w
);
    logic [W:0] nxt_ext;
    assign nxt_ext = {1'b0, count} + {1'b0, step_w};

    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (count == '0) && !wrap); // R2

    AST_ADVANCE_BY_STEP: assert property (@(posedge clk) disable iff (rst)
        (!start && en && (count != max_w) && (nxt_ext <= {1'b0, max_w}))
        |=> (count == $past(nxt_ext[W-1:0])) && !wrap); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!start && !en && (count != max_w)) |=> $stable(count) && !wrap); // R5

    AST_TOP_RETURNS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!start && (count == max_w)) |=> (count == '0) && wrap); // R6

    AST_OVERSHOOT_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (!start && en && (count != max_w) && (nxt_ext > {1'b0, max_w}))
        |=> (count == '0) && wrap); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= max_w); // R9

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (count == '0)); // R9
endmodule

bind strided_wrap_counter strided_wrap_counter_chk #(.W(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .start  (start),
    .count  (count),
    .wrap   (wrap),
    .max_w  (max_q),
    .step_w (step_q)
);

// File: tb/tb_strided_wrap_counter.sv
`timescale 1ns/1ps
module tb_strided_wrap_counter;
    localparam int W    = 4;
    localparam int TOP  = (1 << W) - 1;
    localparam int RUN  = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] cfg_max = '0;
    logic [W-1:0] cfg_step = '0;
    logic [W-1:0] count;
    logic         wrap;

    int checks = 0;
    int errors = 0;
    int m_cnt, m_max, m_step, m_wrap;
    string tag;

    always #10 clk = ~clk;

    strided_wrap_counter #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .cfg_max(cfg_max), .cfg_step(cfg_step),
        .count(count), .wrap(wrap)
    );

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (max=%0d step=%0d)",
                     req, what, got, exp, m_max, m_step);
        end
    endtask

    // Advance the reference by one edge using the inputs driven this cycle
    task automatic tick();
        int s;
        @(posedge clk);
        if (start) begin
            m_cnt = 0; m_wrap = 0; m_max = cfg_max; m_step = cfg_step; tag = "R2";
        end else if (m_cnt == m_max) begin
            m_cnt = 0; m_wrap = 1; tag = (m_max == 0) ? "R8" : "R6";
        end else if (en) begin
            s = m_cnt + m_step;
            if (s > m_max) begin m_cnt = 0; m_wrap = 1; tag = "R7"; end
            else begin
                m_cnt = s; m_wrap = 0;
                tag = (cfg_max != m_max || cfg_step != m_step) ? "R3" : "R4";
            end
        end else begin
            m_wrap = 0; tag = "R5";
        end
        #5;
        check(tag, count, m_cnt, "count");
        check(tag, wrap, m_wrap, "wrap");
        check("R9", (count <= m_max) ? 1 : 0, 1, "count within bound");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        #5 rst = 1'b0;
        m_cnt = 0; m_wrap = 0; m_max = TOP; m_step = 1;
        check("R1", count, 0, "reset count");
        check("R1", wrap, 0, "reset wrap");
        // Default parameters: plain index 0,1,...,TOP then back to 0
        en = 1'b1;
        for (int k = 0; k < 2 * (TOP + 1) + 2; k++) begin
            cfg_max = W'(k * 5); cfg_step = W'(k * 3 + 2);
            tick();
            if (k == TOP - 1) check("R1", count, TOP, "default top");
        end
        // Exhaustive sweep of every wrap point and step
        for (int mx = 0; mx <= TOP; mx++) begin
            for (int st = 0; st <= TOP; st++) begin
                #0;
                start = 1'b1; en = 1'b1;
                cfg_max = W'(mx); cfg_step = W'(st);
                tick();
                start = 1'b0;
                for (int c = 0; c < RUN; c++) begin
                    en = ((c % 5) != 2) && ((c % 7) != 4);
                    cfg_max = W'(mx ^ (c + 1)); cfg_step = W'(st + c + 1);
                    tick();
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule